// File: doc/BRIEF.md
# Delayed Branch Sequencer

This block keeps the program counter of a core in which every branch takes effect one instruction late: the instruction after a branch (its slot) always runs, and only when that slot instruction completes does the counter jump. The decoder presents a branch kind, an immediate or displacement, a register operand and the current T flag with a one-cycle instruction-complete strobe. The block works out the pending target and any return-address update, and it keeps the pending state in a target register and two flags, one for unconditional and one for conditional transfers.

It also restores the status word on return from exception, enters software traps, and flags illegal instructions. An illegal instruction in a slot gets its own exception code. So does any branch or trap placed in a slot. Fetch, decode and exception vectoring sit outside the block. When an exception is raised the counter holds, so the vectoring logic can act on it.

Top module: `delayed_branch_ctrl`

## Requirements
- R1: After reset, `pc` equals the parameter RESET_PC (default 0x100), `pr`, `sr` and `tra` are zero, both slot flags are clear and `excValid` is low.
- R2: While `instrDone` is low, no register changes, whatever `kind` carries. A completed plain instruction (kind 0) outside a slot advances `pc` by STEP (default 2).
- R3: Unconditional branches outside a slot advance `pc` by STEP to the slot and set `slotUncond`. The target is `imm` for kind 1, `imm + regVal` for kind 2 and `regVal` for kind 5. `pc` takes that target when the slot instruction completes.
- R4: The call kinds write `pr` with the branch address plus 2*STEP: kind 3 branches to `imm`, kind 4 to `imm + regVal` and kind 6 to `regVal`. Kind 7 takes its pending target from `pr`.
- R5: Kind 8 (branch if T) and kind 9 (branch if not T) sample `tFlag` at decode and set `slotCond`. After the slot, `pc` takes `imm` if the sampled condition held, and otherwise advances by STEP.
- R6: When a slot instruction completes, both slot flags are clear in the next cycle.
- R7: Kind 10 (return from exception) loads `sr` from `savedSr` at decode and is delayed, with `savedPc` as its target.
- R8: Kind 11 (trap) outside a slot writes `tra` with twice `imm`, pulses `excValid` with `excCode` 0x160 and holds `pc`.
- R9: Kind 12, or any unused kind 13 to 15, outside a slot pulses `excValid` with `excCode` 0x180 and holds `pc`.
- R10: Any nonzero kind that completes inside a slot pulses `excValid` with `excCode` 0x1A0, holds `pc`, leaves `pr`, `sr` and `tra` unchanged, and drops the pending transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Current instruction completes this cycle |
| kind | input | 4 | Branch kind of the completing instruction |
| imm | input | W | Immediate, absolute target or displacement base |
| regVal | input | W | Register operand |
| tFlag | input | 1 | Current T flag |
| savedPc | input | W | Saved PC used by return from exception |
| savedSr | input | W | Saved status word used by return from exception |
| pc | output | W | Program counter |
| pr | output | W | Return-address register |
| sr | output | W | Status word restored by return from exception |
| tra | output | W | Trap value register |
| excValid | output | 1 | One-cycle exception pulse |
| excCode | output | 12 | Exception code, valid with excValid |
| slotUncond | output | 1 | Unconditional transfer pending |
| slotCond | output | 1 | Conditional transfer pending |

## Verification
A pending target that is stored wrongly stays hidden for a full instruction. It shows up only as a wrong `pc` one completion later, so every branch vector is followed by a slot vector whose `pc` is checked. A stuck or lost slot flag shows at the next completion: either a spurious 0x1A0 code or a branch in the slot that is quietly taken. The bench therefore places branches and illegal instructions inside slots and then checks the instruction that follows. A wrong sampled condition shows only after the slot, as a target where a sequential address was expected, or the reverse. For that reason both conditional kinds are run with both values of T.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [3:0] {
    K_PLAIN = 4'd0,  K_BRA  = 4'd1,  K_BRAF = 4'd2, K_BSR  = 4'd3,
    K_BSRF  = 4'd4,  K_JMP  = 4'd5,  K_JSR  = 4'd6, K_RTS  = 4'd7,
    K_BT    = 4'd8,  K_BF   = 4'd9,  K_RTE  = 4'd10, K_TRAP = 4'd11,
    K_ILL   = 4'd12
  } kind_e;

  typedef enum logic [2:0] {T_IMM, T_IMM_REG, T_REG, T_PR, T_SPC} tgt_e;

  typedef enum logic [1:0] {PC_HOLD, PC_SEQ, PC_PEND} pcsel_e;

  localparam logic [11:0] EXC_TRAP = 12'h160;
  localparam logic [11:0] EXC_ILL  = 12'h180;
  localparam logic [11:0] EXC_SLOT = 12'h1A0;

  typedef struct packed {
    logic        loadPend;
    tgt_e        tgtSel;
    logic        writePr;
    pcsel_e      pcSel;
    logic        loadSr;
    logic        loadTra;
    logic        excFire;
    logic [11:0] excCode;
  } strobe_t;

endpackage

// File: rtl/dbr_control.sv
module dbr_control
  import dbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrDone,
  input  logic [3:0] kind,
  input  logic       tFlag,
  output strobe_t    st,
  output logic       slotUncond,
  output logic       slotCond
);

  logic inSlot;
  logic condHeld;
  logic setU;
  logic setC;
  logic takeNow;

  assign inSlot = slotUncond | slotCond;

  always_comb begin
    st       = '0;
    st.pcSel = PC_HOLD;
    setU     = 1'b0;
    setC     = 1'b0;
    takeNow  = 1'b0;
    if (instrDone) begin
      if (inSlot) begin
        if (kind != 4'd0) begin
          st.excFire = 1'b1;
          st.excCode = EXC_SLOT;
        end else begin
          st.pcSel = (slotUncond || condHeld) ? PC_PEND : PC_SEQ;
        end
      end else begin
        unique case (kind)
          K_PLAIN: st.pcSel = PC_SEQ;
          K_BRA:   begin st.tgtSel = T_IMM;     setU = 1'b1; end
          K_BRAF:  begin st.tgtSel = T_IMM_REG; setU = 1'b1; end
          K_BSR:   begin st.tgtSel = T_IMM;     setU = 1'b1; st.writePr = 1'b1; end
          K_BSRF:  begin st.tgtSel = T_IMM_REG; setU = 1'b1; st.writePr = 1'b1; end
          K_JMP:   begin st.tgtSel = T_REG;     setU = 1'b1; end
          K_JSR:   begin st.tgtSel = T_REG;     setU = 1'b1; st.writePr = 1'b1; end
          K_RTS:   begin st.tgtSel = T_PR;      setU = 1'b1; end
          K_BT:    begin st.tgtSel = T_IMM;     setC = 1'b1; takeNow = tFlag; end
          K_BF:    begin st.tgtSel = T_IMM;     setC = 1'b1; takeNow = ~tFlag; end
          K_RTE:   begin st.tgtSel = T_SPC;     setU = 1'b1; st.loadSr = 1'b1; end
          K_TRAP:  begin st.loadTra = 1'b1; st.excFire = 1'b1; st.excCode = EXC_TRAP; end
          default: begin st.excFire = 1'b1; st.excCode = EXC_ILL; end
        endcase
        if (setU || setC) begin
          st.loadPend = 1'b1;
          st.pcSel    = PC_SEQ;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotUncond <= 1'b0;
      slotCond   <= 1'b0;
      condHeld   <= 1'b0;
    end else if (instrDone) begin
      if (inSlot) begin
        slotUncond <= 1'b0;
        slotCond   <= 1'b0;
        condHeld   <= 1'b0;
      end else begin
        slotUncond <= setU;
        slotCond   <= setC;
        condHeld   <= takeNow;
      end
    end
  end

endmodule

// File: rtl/dbr_datapath.sv
module dbr_datapath
  import dbr_pkg::*;
#(
  parameter int unsigned   W        = 32,
  parameter int unsigned   STEP     = 2,
  parameter logic [W-1:0]  RESET_PC = 'h100
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      st,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] regVal,
  input  logic [W-1:0] savedPc,
  input  logic [W-1:0] savedSr,
  output logic [W-1:0] pc,
  output logic [W-1:0] pr,
  output logic [W-1:0] sr,
  output logic [W-1:0] tra,
  output logic         excValid,
  output logic [11:0]  excCode
);

  localparam logic [W-1:0] STEP_W = W'(STEP);
  localparam logic [W-1:0] LINK_W = W'(2 * STEP);

  logic [W-1:0] pending;
  logic [W-1:0] target;

  always_comb begin
    unique case (st.tgtSel)
      T_IMM:     target = imm;
      T_IMM_REG: target = imm + regVal;
      T_REG:     target = regVal;
      T_PR:      target = pr;
      T_SPC:     target = savedPc;
      default:   target = imm;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= RESET_PC;
      pr       <= '0;
      sr       <= '0;
      tra      <= '0;
      pending  <= '0;
      excValid <= 1'b0;
      excCode  <= '0;
    end else begin
      unique case (st.pcSel)
        PC_SEQ:  pc <= pc + STEP_W;
        PC_PEND: pc <= pending;
        default: pc <= pc;
      endcase
      if (st.loadPend) pending <= target;
      if (st.writePr)  pr      <= pc + LINK_W;
      if (st.loadSr)   sr      <= savedSr;
      if (st.loadTra)  tra     <= {imm[W-2:0], 1'b0};
      excValid <= st.excFire;
      if (st.excFire)  excCode <= st.excCode;
    end
  end

endmodule

// File: rtl/delayed_branch_ctrl.sv
module delayed_branch_ctrl
  import dbr_pkg::*;
#(
  parameter int unsigned  W        = 32,
  parameter int unsigned  STEP     = 2,
  parameter logic [W-1:0] RESET_PC = 'h100
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         instrDone,
  input  logic [3:0]   kind,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] regVal,
  input  logic         tFlag,
  input  logic [W-1:0] savedPc,
  input  logic [W-1:0] savedSr,
  output logic [W-1:0] pc,
  output logic [W-1:0] pr,
  output logic [W-1:0] sr,
  output logic [W-1:0] tra,
  output logic         excValid,
  output logic [11:0]  excCode,
  output logic         slotUncond,
  output logic         slotCond
);

  strobe_t st;

  dbr_control u_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .kind(kind), .tFlag(tFlag),
    .st(st), .slotUncond(slotUncond), .slotCond(slotCond)
  );

  dbr_datapath #(.W(W), .STEP(STEP), .RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .imm(imm), .regVal(regVal),
    .savedPc(savedPc), .savedSr(savedSr), .pc(pc), .pr(pr), .sr(sr),
    .tra(tra), .excValid(excValid), .excCode(excCode)
  );

endmodule

// File: rtl/dbr_checker.sv
module dbr_checker #(
  parameter int unsigned W    = 32,
  parameter int unsigned STEP = 2
) (
  input logic         clk,
  input logic         rstN,
  input logic         instrDone,
  input logic [3:0]   kind,
  input logic [W-1:0] pc,
  input logic [W-1:0] pr,
  input logic         excValid,
  input logic [11:0]  excCode,
  input logic         slotUncond,
  input logic         slotCond
);

  logic inSlot;
  assign inSlot = slotUncond | slotCond;

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !instrDone |=> $stable(pc) && $stable(pr) && !excValid);

  a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rstN)
    instrDone && inSlot |=> !slotUncond && !slotCond);

  a_r6_one_flag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({slotUncond, slotCond}));

  a_r4_link: assert property (@(posedge clk) disable iff (!rstN)
    instrDone && !inSlot && (kind == 4'd3 || kind == 4'd4 || kind == 4'd6)
    |=> pr == $past(pc) + W'(2 * STEP));

  a_r8_trap_code: assert property (@(posedge clk) disable iff (!rstN)
    instrDone && !inSlot && kind == 4'd11 |=> excValid && excCode == 12'h160 && $stable(pc));

  a_r9_illegal_code: assert property (@(posedge clk) disable iff (!rstN)
    instrDone && !inSlot && kind >= 4'd12 |=> excValid && excCode == 12'h180 && $stable(pc));

  a_r10_slot_code: assert property (@(posedge clk) disable iff (!rstN)
    instrDone && inSlot && kind != 4'd0 |=> excValid && excCode == 12'h1A0 && $stable(pc));

endmodule

bind delayed_branch_ctrl dbr_checker #(.W(W), .STEP(STEP)) u_dbrChk (
  .clk(clk), .rstN(rstN), .instrDone(instrDone), .kind(kind), .pc(pc), .pr(pr),
  .excValid(excValid), .excCode(excCode), .slotUncond(slotUncond), .slotCond(slotCond)
);

// File: tb/tb_delayed_branch_ctrl.sv
module tb_delayed_branch_ctrl;

  localparam int W = 32;
  localparam int N = 33;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         instrDone = 1'b0;
  logic [3:0]   kind = '0;
  logic [W-1:0] imm = '0;
  logic [W-1:0] regVal = '0;
  logic         tFlag = 1'b0;
  logic [W-1:0] savedPc = '0;
  logic [W-1:0] savedSr = '0;
  logic [W-1:0] pc, pr, sr, tra;
  logic         excValid, slotUncond, slotCond;
  logic [11:0]  excCode;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  delayed_branch_ctrl dut (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .kind(kind), .imm(imm),
    .regVal(regVal), .tFlag(tFlag), .savedPc(savedPc), .savedSr(savedSr),
    .pc(pc), .pr(pr), .sr(sr), .tra(tra), .excValid(excValid), .excCode(excCode),
    .slotUncond(slotUncond), .slotCond(slotCond)
  );

  // kind, imm, regVal, t, expected pc, expected pr, expected exception, expected code
  typedef struct packed {
    logic [3:0]  k;
    logic [31:0] i;
    logic [31:0] r;
    logic        t;
    logic [31:0] ePc;
    logic [31:0] ePr;
    logic        eExc;
    logic [11:0] eCode;
  } vec_t;

  localparam vec_t VECS [N] = '{
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h102,  32'h0,   1'b0, 12'h0},   // R2
    '{4'd1,  32'h200,  32'h0,  1'b0, 32'h104,  32'h0,   1'b0, 12'h0},   // R3
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h200,  32'h0,   1'b0, 12'h0},
    '{4'd3,  32'h300,  32'h0,  1'b0, 32'h202,  32'h204, 1'b0, 12'h0},   // R4
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h300,  32'h204, 1'b0, 12'h0},
    '{4'd7,  32'h0,    32'h0,  1'b0, 32'h302,  32'h204, 1'b0, 12'h0},   // R4
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h204,  32'h204, 1'b0, 12'h0},
    '{4'd2,  32'h1000, 32'h20, 1'b0, 32'h206,  32'h204, 1'b0, 12'h0},   // R3
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h1020, 32'h204, 1'b0, 12'h0},
    '{4'd8,  32'h400,  32'h0,  1'b1, 32'h1022, 32'h204, 1'b0, 12'h0},   // R5
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h400,  32'h204, 1'b0, 12'h0},
    '{4'd9,  32'h500,  32'h0,  1'b1, 32'h402,  32'h204, 1'b0, 12'h0},   // R5
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h404,  32'h204, 1'b0, 12'h0},
    '{4'd6,  32'h0,    32'h600,1'b0, 32'h406,  32'h408, 1'b0, 12'h0},   // R4
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h600,  32'h408, 1'b0, 12'h0},
    '{4'd5,  32'h0,    32'h700,1'b0, 32'h602,  32'h408, 1'b0, 12'h0},   // R3
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h700,  32'h408, 1'b0, 12'h0},
    '{4'd4,  32'h800,  32'h4,  1'b0, 32'h702,  32'h704, 1'b0, 12'h0},   // R4
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h804,  32'h704, 1'b0, 12'h0},
    '{4'd9,  32'h900,  32'h0,  1'b0, 32'h806,  32'h704, 1'b0, 12'h0},   // R5
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h900,  32'h704, 1'b0, 12'h0},
    '{4'd8,  32'hA00,  32'h0,  1'b0, 32'h902,  32'h704, 1'b0, 12'h0},   // R5
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h904,  32'h704, 1'b0, 12'h0},
    '{4'd11, 32'h15,   32'h0,  1'b0, 32'h904,  32'h704, 1'b1, 12'h160}, // R8
    '{4'd12, 32'h0,    32'h0,  1'b0, 32'h904,  32'h704, 1'b1, 12'h180}, // R9
    '{4'd1,  32'hB00,  32'h0,  1'b0, 32'h906,  32'h704, 1'b0, 12'h0},
    '{4'd3,  32'hB80,  32'h0,  1'b0, 32'h906,  32'h704, 1'b1, 12'h1A0}, // R10
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'h908,  32'h704, 1'b0, 12'h0},   // R10
    '{4'd10, 32'h0,    32'h0,  1'b0, 32'h90A,  32'h704, 1'b0, 12'h0},   // R7
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'hC00,  32'h704, 1'b0, 12'h0},   // R7
    '{4'd1,  32'hD00,  32'h0,  1'b0, 32'hC02,  32'h704, 1'b0, 12'h0},
    '{4'd12, 32'h0,    32'h0,  1'b0, 32'hC02,  32'h704, 1'b1, 12'h1A0}, // R10
    '{4'd0,  32'h0,    32'h0,  1'b0, 32'hC04,  32'h704, 1'b0, 12'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] k, input logic [31:0] i, input logic [31:0] r,
                       input logic t);
    kind = k; imm = i; regVal = r; tFlag = t; instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0; kind = '0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    savedPc = 32'hC00;
    savedSr = 32'h0F0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 pc", pc, 32'h100);
    chk("R1 pr", pr, 32'h0);
    chk("R1 sr", sr, 32'h0);
    chk("R1 flags/exc", {29'd0, slotUncond, slotCond, excValid}, 32'h0);

    // R2: a branch kind without the strobe does nothing
    kind = 4'd1; imm = 32'hEEE;
    repeat (3) @(negedge clk);
    chk("R2 idle pc", pc, 32'h100);
    chk("R2 idle flag", {31'd0, slotUncond}, 32'h0);
    kind = '0;

    for (int n = 0; n < N; n++) begin
      issue(VECS[n].k, VECS[n].i, VECS[n].r, VECS[n].t);
      chk($sformatf("R2-table pc step %0d", n), pc, VECS[n].ePc);
      chk($sformatf("R4 pr step %0d", n), pr, VECS[n].ePr);
      chk($sformatf("R8 R9 R10 exc step %0d", n), {31'd0, excValid}, {31'd0, VECS[n].eExc});
      if (VECS[n].eExc) chk($sformatf("R8 R9 R10 code step %0d", n), {20'd0, excCode}, {20'd0, VECS[n].eCode});
      if (n == 23) chk("R8 tra", tra, 32'h2A);
      if (n == 28) chk("R7 sr", sr, 32'h0F0);
      if (n == 26) chk("R10 sr/tra kept", sr ^ tra, 32'h2A);
    end

    // R6 / R3: flag persists across idle cycles, clears after slot
    issue(4'd1, 32'h2000, 32'h0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R3 flag held", {31'd0, slotUncond}, 32'h1);
    chk("R3 pc at slot", pc, 32'hC06);
    issue(4'd0, 32'h0, 32'h0, 1'b0);
    chk("R6 flags clear", {30'd0, slotUncond, slotCond}, 32'h0);
    chk("R3 target", pc, 32'h2000);

    // R5 conditional flag
    issue(4'd8, 32'h3000, 32'h0, 1'b1);
    chk("R5 cond flag", {30'd0, slotUncond, slotCond}, 32'h1);
    issue(4'd0, 32'h0, 32'h0, 1'b0);
    chk("R6 cond clear", {31'd0, slotCond}, 32'h0);
    chk("R5 taken", pc, 32'h3000);

    // R9 unused kind
    issue(4'd15, 32'h0, 32'h0, 1'b0);
    chk("R9 unused kind code", {19'd0, excValid, excCode}, {19'd0, 1'b1, 12'h180});
    chk("R9 pc held", pc, 32'h3000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule